// File: doc/BRIEF.md
# Serial Memory Slave Command Front-End

This block is the command side of a serial-attached memory that always acts as the slave on an SPI bus. It oversamples the chip-select, serial clock, serial input and hold pins with the core clock. It gathers the opcode, the address bytes and the write bytes, each most significant bit first, and turns them into single-cycle strobes for a downstream control block. It also shifts out response bytes: the status byte supplied by that control block, read data supplied by the array model, and a fixed three-byte identity.

A transaction starts when chip select falls. The first byte is the opcode. A known opcode raises one bit of a one-hot command strobe. An unknown opcode leaves SO undriven and makes the block deaf until chip select falls again. While hold is low, clock edges are ignored and SO is released, and the transfer later resumes at the same bit. The strobe outputs have no ready: the serial master cannot be stalled, so the consumer must take every pulse in the cycle it appears. Read data must be valid within half an SCK period after `rd_req`.

Top module: `spi_mem_slave_fe`

## Requirements
- R1: The first byte after a falling edge of `cs_n` is the opcode, taken MSB first; a falling edge of `cs_n` discards any partial sequence and restarts from bit 0 of the opcode.
- R2: SI is sampled on rising SCK and SO changes only on falling SCK. SPI mode 0 (SCK idle low) and mode 3 (SCK idle high) behave identically.
- R3: Opcode 0xAB is followed by three ignored dummy bytes. SO then drives 0x9D, then the device code (0x7C when `MEM_1MBIT`=1, 0x7B when 0), then 0x7F. After these three bytes SO is released.
- R4: Opcode 0x05 drives `status_in` on SO in every byte that follows the opcode, for as long as `cs_n` stays low.
- R5: An unrecognised opcode raises no strobe, keeps SO released and ignores all SCK edges until the next falling edge of `cs_n`.
- R6: A recognised opcode pulses `cmd_hit` for one cycle with exactly one bit set. The bits are: 0 WREN 0x06, 1 WRDI 0x04, 2 RDSR 0x05, 3 WRSR 0x01, 4 READ 0x03, 5 page program 0x02, 6 sector erase 0xD7, 7 block erase 0xD8, 8 chip erase 0xC7, 9 identity 0xAB.
- R7: For READ, page program, sector erase and block erase, the three bytes after the opcode form `addr` (first byte in bits 23:16). `addr_valid` pulses once when the third address byte completes. No other opcode pulses `addr_valid`.
- R8: `wdata_valid` pulses with `wdata` for each byte after the address of a page program, and for the single byte after a WRSR opcode.
- R9: For READ, `rd_req` pulses when the last address byte completes and again at the end of every later byte. `rd_data` is taken at the next falling SCK and shifted out as the next byte.
- R10: While `hold_n` is low, SO is released and SCK edges are ignored. After release, shifting continues from the same bit.
- R11: Once `cs_n` has been high for three core cycles, `so_oe` is low.
- R12: After reset, `so_oe`, `cmd_hit`, `addr_valid`, `wdata_valid` and `rd_req` are low and `addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; at least 8x the SCK rate |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data into the slave |
| hold_n | input | 1 | Pause, active low |
| status_in | input | 8 | Status byte returned by RDSR |
| rd_data | input | 8 | Array byte for READ, valid after `rd_req` |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for SO pad |
| cmd_hit | output | 10 | One-hot command strobe |
| addr | output | 24 | Captured address |
| addr_valid | output | 1 | Address complete strobe |
| wdata | output | 8 | Write byte |
| wdata_valid | output | 1 | Write byte strobe |
| rd_req | output | 1 | Request for next read byte |

## Verification
Every result trails the pin event that causes it by three core cycles: two synchroniser stages and one register. Strobes appear three cycles after the SCK rise that completes a byte. A new SO bit appears three cycles after an SCK fall. The enable drops no more than three cycles after `cs_n` or `hold_n` is deasserted. The bench holds each SCK phase for eight core cycles and samples SO at the end of the low phase, well past the update. It reads strobes through a monitor that has settled long before the byte task returns, so no check sits near a moving edge.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int NUM_CMD     = 10;
  localparam int DUMMY_BYTES = 3;
  localparam int C_WREN = 0;
  localparam int C_WRDI = 1;
  localparam int C_RDSR = 2;
  localparam int C_WRSR = 3;
  localparam int C_READ = 4;
  localparam int C_PROG = 5;
  localparam int C_SECT = 6;
  localparam int C_BLK  = 7;
  localparam int C_CHIP = 8;
  localparam int C_RDID = 9;
  typedef logic [NUM_CMD-1:0] cmd_vec_t;
endpackage

// File: rtl/spi_fe_pins.sv
module spi_fe_pins #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic held,
  output logic si_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sck_q, cs_q, si_q, hold_q;
  logic sck_prev, cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= '0;
      cs_q     <= '1;
      si_q     <= '0;
      hold_q   <= '1;
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      sck_q    <= {sck_q[TOP-1:0], sck};
      cs_q     <= {cs_q[TOP-1:0], cs_n};
      si_q     <= {si_q[TOP-1:0], si};
      hold_q   <= {hold_q[TOP-1:0], hold_n};
      sck_prev <= sck_q[TOP];
      cs_prev  <= cs_q[TOP];
    end
  end

  assign sel      = ~cs_q[TOP];
  assign held     = ~hold_q[TOP];
  assign si_s     = si_q[TOP];
  assign sck_rise = sel & ~held & sck_q[TOP] & ~sck_prev;
  assign sck_fall = sel & ~held & ~sck_q[TOP] & sck_prev;
  assign cs_fall  = cs_prev & ~cs_q[TOP];
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 4,
  parameter logic [NUM_CMD*8-1:0] OP_TABLE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              cs_fall,
  input  logic              si,
  output logic [2:0]        bit_cnt,
  output logic [CNT_W-1:0]  byte_cnt,
  output cmd_vec_t          cmd,
  output logic              dead,
  output cmd_vec_t          cmd_hit,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid,
  output logic [7:0]        wdata,
  output logic              wdata_valid,
  output logic              rd_req
);
  localparam logic [CNT_W-1:0] A_LAST  = CNT_W'(ADDR_W / 8);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [6:0] sh;
  logic [7:0] nb;
  cmd_vec_t   match;
  logic       is_addr, in_addr, last_bit;

  assign nb = {sh, si};

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_match
    assign match[g] = (nb == OP_TABLE[g*8 +: 8]);
  end

  assign is_addr  = cmd[C_READ] | cmd[C_PROG] | cmd[C_SECT] | cmd[C_BLK];
  assign in_addr  = is_addr && (byte_cnt >= ONE) && (byte_cnt <= A_LAST);
  assign last_bit = (bit_cnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; bit_cnt <= '0; byte_cnt <= '0; cmd <= '0; dead <= 1'b0;
      cmd_hit <= '0; addr <= '0; addr_valid <= 1'b0;
      wdata <= '0; wdata_valid <= 1'b0; rd_req <= 1'b0;
    end else begin
      cmd_hit     <= '0;
      addr_valid  <= 1'b0;
      wdata_valid <= 1'b0;
      rd_req      <= 1'b0;
      if (cs_fall) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        cmd      <= '0;
        dead     <= 1'b0;
      end else if (rise && !dead) begin
        sh      <= nb[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (last_bit) begin
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + ONE;
          if (byte_cnt == '0) begin
            if (|match) begin
              cmd     <= match;
              cmd_hit <= match;
            end else begin
              dead <= 1'b1;
            end
          end else begin
            if (in_addr) addr <= {addr[ADDR_W-9:0], nb};
            addr_valid <= in_addr && (byte_cnt == A_LAST);
            rd_req     <= cmd[C_READ] && (byte_cnt >= A_LAST);
            if ((cmd[C_PROG] && byte_cnt > A_LAST) ||
                (cmd[C_WRSR] && byte_cnt == ONE)) begin
              wdata       <= nb;
              wdata_valid <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
  import spi_fe_pkg::*;
#(
  parameter int         CNT_W      = 4,
  parameter int         ADDR_BYTES = 3,
  parameter logic [7:0] ID_FIRST   = 8'h9D,
  parameter logic [7:0] ID_DEV     = 8'h7C,
  parameter logic [7:0] ID_LAST    = 8'h7F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             sel,
  input  logic             held,
  input  logic             dead,
  input  cmd_vec_t         cmd,
  input  logic [2:0]       bit_cnt,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [7:0]       status_in,
  input  logic [7:0]       rd_data,
  output logic             so,
  output logic             so_oe
);
  localparam logic [CNT_W-1:0] ID0    = CNT_W'(DUMMY_BYTES + 1);
  localparam logic [CNT_W-1:0] ID1    = CNT_W'(DUMMY_BYTES + 2);
  localparam logic [CNT_W-1:0] ID2    = CNT_W'(DUMMY_BYTES + 3);
  localparam logic [CNT_W-1:0] DFIRST = CNT_W'(ADDR_BYTES + 1);

  logic [7:0] next_byte, out_byte;
  logic       phase;

  always_comb begin
    next_byte = '0;
    if (cmd[C_RDSR])      next_byte = status_in;
    else if (cmd[C_READ]) next_byte = rd_data;
    else if (cmd[C_RDID]) begin
      if (byte_cnt == ID0)      next_byte = ID_FIRST;
      else if (byte_cnt == ID1) next_byte = ID_DEV;
      else if (byte_cnt == ID2) next_byte = ID_LAST;
    end
  end

  assign phase = (cmd[C_RDSR] && byte_cnt != '0) ||
                 (cmd[C_READ] && byte_cnt >= DFIRST) ||
                 (cmd[C_RDID] && byte_cnt >= ID0 && byte_cnt <= ID2);
  assign so_oe = sel & ~held & ~dead & phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte <= '0;
      so       <= 1'b0;
    end else if (fall) begin
      if (bit_cnt == 3'd0) begin
        out_byte <= next_byte;
        so       <= next_byte[7];
      end else begin
        so <= out_byte[3'd7 - bit_cnt];
      end
    end
  end
endmodule

// File: rtl/spi_mem_slave_fe.sv
module spi_mem_slave_fe
  import spi_fe_pkg::*;
#(
  parameter bit         MEM_1MBIT   = 1'b1,
  parameter int         ADDR_W      = 24,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_WRDI = 8'h04,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_WRSR = 8'h01,
  parameter logic [7:0] OP_READ = 8'h03,
  parameter logic [7:0] OP_PROG = 8'h02,
  parameter logic [7:0] OP_SECT = 8'hD7,
  parameter logic [7:0] OP_BLK  = 8'hD8,
  parameter logic [7:0] OP_CHIP = 8'hC7,
  parameter logic [7:0] OP_RDID = 8'hAB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                si,
  input  logic                hold_n,
  input  logic [7:0]          status_in,
  input  logic [7:0]          rd_data,
  output logic                so,
  output logic                so_oe,
  output logic [NUM_CMD-1:0]  cmd_hit,
  output logic [ADDR_W-1:0]   addr,
  output logic                addr_valid,
  output logic [7:0]          wdata,
  output logic                wdata_valid,
  output logic                rd_req
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_W      = $clog2(ADDR_BYTES + DUMMY_BYTES + 4);
  localparam logic [7:0] DEV_CODE = MEM_1MBIT ? 8'h7C : 8'h7B;
  localparam logic [NUM_CMD*8-1:0] OP_TABLE =
    {OP_RDID, OP_CHIP, OP_BLK, OP_SECT, OP_PROG,
     OP_READ, OP_WRSR, OP_RDSR, OP_WRDI, OP_WREN};

  logic             sel, held, si_s, sck_rise, sck_fall, cs_fall, dead;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  cmd_vec_t         cmd;

  spi_fe_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .sel(sel), .held(held), .si_s(si_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall)
  );

  spi_fe_rx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OP_TABLE(OP_TABLE)) u_rx (
    .clk(clk), .rst(rst), .rise(sck_rise), .cs_fall(cs_fall), .si(si_s),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .cmd(cmd), .dead(dead),
    .cmd_hit(cmd_hit), .addr(addr), .addr_valid(addr_valid),
    .wdata(wdata), .wdata_valid(wdata_valid), .rd_req(rd_req)
  );

  spi_fe_tx #(.CNT_W(CNT_W), .ADDR_BYTES(ADDR_BYTES), .ID_FIRST(8'h9D),
              .ID_DEV(DEV_CODE), .ID_LAST(8'h7F)) u_tx (
    .clk(clk), .rst(rst), .fall(sck_fall), .sel(sel), .held(held),
    .dead(dead), .cmd(cmd), .bit_cnt(bit_cnt), .byte_cnt(byte_cnt),
    .status_in(status_in), .rd_data(rd_data), .so(so), .so_oe(so_oe)
  );
endmodule

// File: rtl/spi_mem_slave_fe_chk.sv
module spi_mem_slave_fe_chk
  import spi_fe_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     cs_n,
  input logic     sck,
  input logic     hold_n,
  input logic     so,
  input logic     so_oe,
  input cmd_vec_t cmd_hit,
  input logic     addr_valid,
  input logic     wdata_valid
);
  assert_cs_release_R11: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2)) |-> !so_oe);

  assert_one_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_hit));

  assert_so_on_fall_only_R2: assert property (@(posedge clk) disable iff (rst)
    (sck == $past(sck) && sck == $past(sck, 2) && sck == $past(sck, 3) &&
     sck == $past(sck, 4)) |-> $stable(so));

  assert_addr_before_data_R7: assert property (@(posedge clk) disable iff (rst)
    !(addr_valid && wdata_valid));
endmodule

bind spi_mem_slave_fe spi_mem_slave_fe_chk u_chk (.*);

// File: tb/spi_mem_slave_fe_bench.sv
module spi_mem_slave_fe_bench;
  localparam int HALF = 8;

  typedef struct packed {
    logic        mode3;
    logic [2:0]  len;
    logic [55:0] tx;
    logic [55:0] exp;
    logic [6:0]  chk;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b0, 3'd7, 56'hAB000000000000, 56'h000000009D7C7F, 7'b1110000},
    '{1'b1, 3'd7, 56'hAB000000000000, 56'h000000009D7C7F, 7'b1110000},
    '{1'b0, 3'd4, 56'h05000000000000, 56'h008C8C8C000000, 7'b0001110},
    '{1'b1, 3'd4, 56'h05000000000000, 56'h008C8C8C000000, 7'b0001110},
    '{1'b0, 3'd4, 56'h9FAB0000000000, 56'h00FFFFFF000000, 7'b0001110},
    '{1'b1, 3'd4, 56'h9F050000000000, 56'h00FFFFFF000000, 7'b0001110}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] status_in = 8'h8C;
  logic [7:0] rd_data;
  logic so, so_oe, addr_valid, wdata_valid, rd_req, so_bus;
  logic [9:0] cmd_hit;
  logic [23:0] addr;
  logic [7:0] wdata;

  int n_chk = 0, n_bad = 0;
  int cmd_cnt = 0, addr_cnt = 0, w_cnt = 0, rd_cnt = 0;
  logic [9:0]  last_cmd = '0;
  logic [23:0] last_addr = '0;
  logic [7:0]  w_last = '0, w_prev = '0;

  assign rd_data = 8'hA0 + 8'(rd_cnt);
  assign so_bus  = so_oe ? so : 1'b1;

  spi_mem_slave_fe u_spi_mem_slave_fe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .status_in(status_in), .rd_data(rd_data), .so(so), .so_oe(so_oe),
    .cmd_hit(cmd_hit), .addr(addr), .addr_valid(addr_valid),
    .wdata(wdata), .wdata_valid(wdata_valid), .rd_req(rd_req)
  );

  always @(posedge clk) begin
    if (|cmd_hit) begin last_cmd <= cmd_hit; cmd_cnt <= cmd_cnt + 1; end
    if (addr_valid) begin last_addr <= addr; addr_cnt <= addr_cnt + 1; end
    if (wdata_valid) begin w_prev <= w_last; w_last <= wdata; w_cnt <= w_cnt + 1; end
    if (rd_req) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    @(negedge clk);
    sck = 1'b0; si = b;
    idle(HALF);
    r = so_bus;
    sck = 1'b1;
    idle(HALF);
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      xbit(t[i], b);
      r[i] = b;
    end
  endtask

  task automatic sel_on(input logic mode3);
    sck = mode3; idle(HALF);
    cs_n = 1'b0; idle(HALF);
  endtask

  task automatic sel_off(input logic mode3);
    if (!mode3) sck = 1'b0;
    idle(HALF);
    cs_n = 1'b1; idle(2 * HALF);
  endtask

  function automatic string tag_of(input logic [7:0] op);
    if (op == 8'hAB) return "R3 R2";
    if (op == 8'h05) return "R4 R2";
    return "R5 R2";
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] r, r2;
    logic [7:0] asm;
    int w0, c0, a0;
    idle(6);
    rst = 1'b0;
    idle(2);
    // R12 reset state
    check("R12 so_oe", 32'(so_oe), 32'd0);
    check("R12 cmd_hit", 32'(cmd_hit), 32'd0);
    check("R12 strobes", {29'd0, addr_valid, wdata_valid, rd_req}, 32'd0);
    check("R12 addr", 32'(addr), 32'd0);

    // Table: identity, status, unknown opcode, both SPI modes
    for (int v = 0; v < 6; v++) begin
      sel_on(VECS[v].mode3);
      for (int k = 0; k < int'(VECS[v].len); k++) begin
        xbyte(VECS[v].tx[55-8*k -: 8], r);
        if (VECS[v].chk[k])
          check(tag_of(VECS[v].tx[55:48]), 32'(r), 32'(VECS[v].exp[55-8*k -: 8]));
      end
      sel_off(VECS[v].mode3);
    end
    check("R5 no strobe on unknown opcode", cmd_cnt, 32'd4);
    check("R6 last strobe RDSR bit2", 32'(last_cmd), 32'h004);

    // R1: partial opcode then restart
    sel_on(1'b0);
    for (int i = 0; i < 3; i++) begin logic b; xbit(1'b1, b); end
    sel_off(1'b0);
    sel_on(1'b0); xbyte(8'h06, r); sel_off(1'b0);
    check("R1 restart then WREN bit0", 32'(last_cmd), 32'h001);
    check("R1 single strobe", cmd_cnt, 32'd5);

    // R6 WRDI in mode 3
    sel_on(1'b1); xbyte(8'h04, r); sel_off(1'b1);
    check("R6 WRDI bit1", 32'(last_cmd), 32'h002);

    // R7 R8 page program
    a0 = addr_cnt; w0 = w_cnt;
    sel_on(1'b0);
    xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h10, r); xbyte(8'h20, r);
    xbyte(8'hAA, r); xbyte(8'h55, r);
    sel_off(1'b0);
    check("R6 program bit5", 32'(last_cmd), 32'h020);
    check("R7 program address", 32'(last_addr), 32'h001020);
    check("R7 one address strobe", addr_cnt - a0, 32'd1);
    check("R8 first write byte", 32'(w_prev), 32'hAA);
    check("R8 second write byte", 32'(w_last), 32'h55);
    check("R8 write count", w_cnt - w0, 32'd2);

    // R8 WRSR
    a0 = addr_cnt;
    sel_on(1'b1); xbyte(8'h01, r); xbyte(8'h3C, r); sel_off(1'b1);
    check("R6 WRSR bit3", 32'(last_cmd), 32'h008);
    check("R8 status write byte", 32'(w_last), 32'h3C);
    check("R7 no address for WRSR", addr_cnt - a0, 32'd0);

    // R6 R7 erases
    sel_on(1'b0); xbyte(8'hD7, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h40, r); sel_off(1'b0);
    check("R6 sector bit6", 32'(last_cmd), 32'h040);
    check("R7 sector address", 32'(last_addr), 32'h000040);
    sel_on(1'b1); xbyte(8'hD8, r); xbyte(8'h01, r); xbyte(8'h00, r); xbyte(8'h00, r); sel_off(1'b1);
    check("R6 block bit7", 32'(last_cmd), 32'h080);
    check("R7 block address", 32'(last_addr), 32'h010000);
    sel_on(1'b0); xbyte(8'hC7, r); sel_off(1'b0);
    check("R6 chip bit8", 32'(last_cmd), 32'h100);

    // R9 READ
    c0 = rd_cnt;
    sel_on(1'b0);
    xbyte(8'h03, r); xbyte(8'h12, r); xbyte(8'h34, r); xbyte(8'h56, r);
    xbyte(8'h00, r); xbyte(8'h00, r2);
    sel_off(1'b0);
    check("R7 read address", 32'(last_addr), 32'h123456);
    check("R9 first read byte", 32'(r), 32'(8'hA0 + 8'(c0 + 1)));
    check("R9 second read byte", 32'(r2), 32'(8'hA0 + 8'(c0 + 2)));
    check("R9 request count", rd_cnt - c0, 32'd3);

    // R10 hold inside the device code byte
    sel_on(1'b0);
    xbyte(8'hAB, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r);
    xbyte(8'h00, r);
    check("R10 first id before hold", 32'(r), 32'h9D);
    asm = '0;
    for (int i = 7; i >= 5; i--) begin logic b; xbit(1'b0, b); asm[i] = b; end
    @(negedge clk); hold_n = 1'b0;
    idle(4);
    check("R10 SO released in hold", 32'(so_oe), 32'd0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; idle(HALF); sck = 1'b1; idle(HALF);
    end
    hold_n = 1'b1; idle(HALF);
    for (int i = 4; i >= 0; i--) begin logic b; xbit(1'b0, b); asm[i] = b; end
    check("R10 device code across hold", 32'(asm), 32'h7C);
    xbyte(8'h00, r);
    check("R10 last id after hold", 32'(r), 32'h7F);
    xbyte(8'h00, r);
    check("R3 SO released after identity", 32'(r), 32'hFF);
    sel_off(1'b0);

    // R11 chip select release mid status read
    sel_on(1'b0);
    xbyte(8'h05, r); xbyte(8'h00, r);
    check("R4 status byte", 32'(r), 32'h8C);
    check("R4 SO driven while selected", 32'(so_oe), 32'd1);
    @(negedge clk); cs_n = 1'b1;
    idle(3);
    check("R11 SO released after deselect", 32'(so_oe), 32'd0);
    sck = 1'b0; idle(2 * HALF);

    summary();
  end
endmodule